// File: doc/BRIEF.md
# Reset Cause and Software Reset Register Bank

This block is a compact 32-bit register bank that sits beside a reset controller. It keeps a sticky, multi-hot record of the reasons the device came out of reset. Hardware raises one event line per reason. Software reads the record and acknowledges reasons by writing ones to the matching bits.

The bank also owns a parameterised set of software reset channels. Each channel drives one active-low peripheral reset output from a control bit. Each control bit is guarded by a lock bit that can only move from open to closed. Once software closes a channel's lock, that channel's reset level is frozen until the next full reset.

Access is through a plain word-addressed read/write port. Reads are combinational from the current register state. Writes take effect at the next rising clock edge. The reset input is active low and asynchronous, and it is assumed to be released synchronously by the surrounding reset logic.

Top module: `rstcause_regbank`

## Requirements
- R1: While and after reset, the cause field reads 0x01, every lock bit reads 1, every control bit reads 1, and every reset output is high.
- R2: A high event input sets its cause bit at the next clock edge, and bits already set stay set. The bit positions are: bit 0 power-on, bit 1 low-power exit, bit 2 watchdog, bit 3 security escalation, bit 4 non-debug-module request. Several bits may be set at once.
- R3: A write to word address 0 clears each cause bit whose write-data bit (data bits 4:0) is 1. Cause bits whose write-data bit is 0 keep their value.
- R4: If an event and a write-1 clear hit the same cause bit in the same cycle, the bit is 1 after the edge.
- R5: Channel i's lock bit is at word address 1+2i, in data bit 0. Writing 1 there clears it. Writing 0 leaves it unchanged. Once it is 0, it stays 0 until reset.
- R6: Channel i's control bit is at word address 2+2i, in data bit 0. While the lock is 1, a write loads data bit 0 into the control bit at the next edge.
- R7: While channel i's lock is 0, writes to its control bit are ignored and its output holds its level.
- R8: Read data bits that are not implemented (bits 31:5 of the cause word, and bits 31:1 of the lock and control words) read 0. Write data in those bits has no effect.
- R9: Word addresses above 2*NUM_CH read 0, and writes to them change no register.
- R10: Reset output i is a register output that always equals channel i's control bit. It is driven low when the control bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | ADDR_W | Word address of the access |
| reg_wdata_i | input | DATA_W | Write data |
| reg_we_i | input | 1 | Write strobe, sampled at the rising edge |
| reg_rdata_o | output | DATA_W | Combinational read data for reg_addr_i |
| cause_evt_i | input | 5 | Per-reason hardware reset events |
| sw_rst_no | output | NUM_CH | Active-low software reset outputs, one per channel |

## Verification
The hardest situation to reach from the ports is a lock that is already closed while a control write arrives, and especially a channel that was locked with its output held low. Reaching it takes an ordered sequence: drive the output low, close the lock, then try to release the output. Afterwards a full reset must reopen the lock. The bench walks that sequence on separate channels and checks that the remaining channels stay writable. It also lines up an event with a write-1 clear of the same cause bit in the same cycle. A long mixed pass then sweeps mapped and unmapped addresses against the reference model on every clock.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  // Width of the multi-hot reset cause field
  localparam int unsigned CAUSE_W = 5;

  // Bit positions inside the cause field
  localparam int unsigned CAUSE_POR_BIT  = 0;
  localparam int unsigned CAUSE_LPE_BIT  = 1;
  localparam int unsigned CAUSE_WDOG_BIT = 2;
  localparam int unsigned CAUSE_ESC_BIT  = 3;
  localparam int unsigned CAUSE_NDM_BIT  = 4;

  // Value after reset: only the power-on reason is recorded
  localparam logic [CAUSE_W-1:0] CAUSE_RST_VAL = CAUSE_W'(1) << CAUSE_POR_BIT;

  // Word address map
  localparam int unsigned CAUSE_ADDR = 0;

  function automatic int unsigned lock_addr(input int unsigned ch);
    return 1 + 2 * ch;
  endfunction

  function automatic int unsigned ctrl_addr(input int unsigned ch);
    return 2 + 2 * ch;
  endfunction
endpackage

// File: rtl/rcr_decode.sv
module rcr_decode
  import rcr_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cause_hit_o,
  output logic [NUM_CH-1:0] lock_hit_o,
  output logic [NUM_CH-1:0] ctrl_hit_o
);
  assign cause_hit_o = (addr_i == ADDR_W'(CAUSE_ADDR));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] LockA = ADDR_W'(lock_addr(g));
    localparam logic [ADDR_W-1:0] CtrlA = ADDR_W'(ctrl_addr(g));
    assign lock_hit_o[g] = (addr_i == LockA);
    assign ctrl_hit_o[g] = (addr_i == CtrlA);
  end
endmodule

// File: rtl/rcr_cause.sv
module rcr_cause
  import rcr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CAUSE_W-1:0] evt_i,
  input  logic               clr_en_i,
  input  logic [CAUSE_W-1:0] clr_mask_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic               cause_en;

  // Clear first, then OR events in, so an event beats a same-cycle clear
  always_comb begin
    cause_d = cause_q;
    if (clr_en_i) begin
      cause_d = cause_d & ~clr_mask_i;
    end
    cause_d  = cause_d | evt_i;
    cause_en = clr_en_i | (|evt_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= CAUSE_RST_VAL;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/rcr_swchan.sv
module rcr_swchan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_we_i,
  input  logic ctrl_we_i,
  input  logic wbit_i,
  output logic lock_o,
  output logic ctrl_o
);
  logic lock_q, lock_d, lock_en;
  logic ctrl_q, ctrl_d, ctrl_en;

  always_comb begin
    // Lock can only fall: a written 1 closes it
    lock_en = lock_we_i;
    lock_d  = lock_q & ~wbit_i;
    // Control accepts writes only while the lock is still open
    ctrl_en = ctrl_we_i & lock_q;
    ctrl_d  = wbit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b1;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 1'b1;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign lock_o = lock_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/rcr_rdmux.sv
module rcr_rdmux
  import rcr_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic               cause_hit_i,
  input  logic [NUM_CH-1:0]  lock_hit_i,
  input  logic [NUM_CH-1:0]  ctrl_hit_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [NUM_CH-1:0]  lock_i,
  input  logic [NUM_CH-1:0]  ctrl_i,
  output logic [DATA_W-1:0]  rdata_o
);
  logic bit0_sel;

  // Hits are mutually exclusive, so an OR tree is enough
  always_comb begin
    bit0_sel = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      bit0_sel = bit0_sel | (lock_hit_i[i] & lock_i[i]) | (ctrl_hit_i[i] & ctrl_i[i]);
    end
    rdata_o = '0;
    if (cause_hit_i) begin
      rdata_o[CAUSE_W-1:0] = cause_i;
    end
    rdata_o[0] = rdata_o[0] | bit0_sel;
  end
endmodule

// File: rtl/rstcause_regbank.sv
module rstcause_regbank
  import rcr_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  input  logic               reg_we_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic [CAUSE_W-1:0] cause_evt_i,
  output logic [NUM_CH-1:0]  sw_rst_no
);
  localparam int unsigned LastAddr = 2 * NUM_CH;

  logic               cause_hit;
  logic [NUM_CH-1:0]  lock_hit, ctrl_hit;
  logic [CAUSE_W-1:0] cause_q;
  logic [NUM_CH-1:0]  lock_q, ctrl_q;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:CAUSE_W];

  rcr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
    .addr_i      (reg_addr_i),
    .cause_hit_o (cause_hit),
    .lock_hit_o  (lock_hit),
    .ctrl_hit_o  (ctrl_hit)
  );

  rcr_cause u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (cause_evt_i),
    .clr_en_i   (reg_we_i & cause_hit),
    .clr_mask_i (reg_wdata_i[CAUSE_W-1:0]),
    .cause_o    (cause_q)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    rcr_swchan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lock_we_i (reg_we_i & lock_hit[g]),
      .ctrl_we_i (reg_we_i & ctrl_hit[g]),
      .wbit_i    (reg_wdata_i[0]),
      .lock_o    (lock_q[g]),
      .ctrl_o    (ctrl_q[g])
    );
  end

  rcr_rdmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rdmux (
    .cause_hit_i (cause_hit),
    .lock_hit_i  (lock_hit),
    .ctrl_hit_i  (ctrl_hit),
    .cause_i     (cause_q),
    .lock_i      (lock_q),
    .ctrl_i      (ctrl_q),
    .rdata_o     (reg_rdata_o)
  );

  // Outputs come straight from flops: no decode glitches reach a reset pin
  assign sw_rst_no = ctrl_q;

  if (LastAddr >= (1 << ADDR_W)) begin : g_bad_cfg
    initial $error("ADDR_W too narrow for NUM_CH channels");
  end
endmodule

// File: rtl/rcr_checker.sv
module rcr_checker
  import rcr_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [DATA_W-1:0]  reg_wdata_i,
  input logic               reg_we_i,
  input logic [DATA_W-1:0]  reg_rdata_o,
  input logic [CAUSE_W-1:0] cause_evt_i,
  input logic [NUM_CH-1:0]  sw_rst_no,
  input logic [CAUSE_W-1:0] cause_q,
  input logic [NUM_CH-1:0]  lock_q,
  input logic [NUM_CH-1:0]  ctrl_q
);
  localparam int unsigned LastAddr = 2 * NUM_CH;

  // Events set their bits, even against a same-cycle clear
  assert_evt_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cause_evt_i) |=> ((cause_q & $past(cause_evt_i)) == $past(cause_evt_i)));

  // A cause bit never rises without its event
  assert_no_spurious_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(cause_evt_i)) == '0));

  // Upper read bits are always zero
  assert_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[DATA_W-1:CAUSE_W] == '0);

  // Unmapped reads return zero
  assert_unmapped_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(reg_addr_i) > LastAddr) |-> (reg_rdata_o == '0));

  // Outputs track the control bits
  assert_out_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_no == ctrl_q);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] CtrlA = ADDR_W'(ctrl_addr(g));

    assert_lock_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lock_q[g] |=> !lock_q[g]);

    assert_open_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && reg_addr_i == CtrlA && lock_q[g]) |=> (ctrl_q[g] == $past(reg_wdata_i[0])));

    assert_locked_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lock_q[g] |=> $stable(ctrl_q[g]));
  end
endmodule

bind rstcause_regbank rcr_checker #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_we_i    (reg_we_i),
  .reg_rdata_o (reg_rdata_o),
  .cause_evt_i (cause_evt_i),
  .sw_rst_no   (sw_rst_no),
  .cause_q     (cause_q),
  .lock_q      (lock_q),
  .ctrl_q      (ctrl_q)
);

// File: tb/rstcause_regbank_tb.sv
module rstcause_regbank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int AW  = 6;
  localparam int DW  = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [AW-1:0] reg_addr_i;
  logic [DW-1:0] reg_wdata_i;
  logic          reg_we_i;
  logic [DW-1:0] reg_rdata_o;
  logic [4:0]    cause_evt_i;
  logic [NCH-1:0] sw_rst_no;

  int total = 0;
  int fails = 0;

  // Reference state
  logic [4:0]     m_cause;
  logic [NCH-1:0] m_lock;
  logic [NCH-1:0] m_ctrl;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rstcause_regbank #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_we_i(reg_we_i), .reg_rdata_o(reg_rdata_o), .cause_evt_i(cause_evt_i),
    .sw_rst_no(sw_rst_no)
  );

  function automatic logic [DW-1:0] model_read(input int a);
    if (a == 0) return {27'b0, m_cause};
    if (a >= 1 && a <= 2*NCH) begin
      if ((a - 1) % 2 == 0) return {31'b0, m_lock[(a-1)/2]};
      return {31'b0, m_ctrl[(a-1)/2]};
    end
    return '0;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cause = 5'h01;
    m_lock  = '1;
    m_ctrl  = '1;
  endtask

  // One clock: drive at negedge, compare before the edge, update model at the edge
  task automatic cyc(input int a, input logic [DW-1:0] d, input bit w, input logic [4:0] e,
                     input string tag);
    logic [NCH-1:0] old_lock;
    reg_addr_i = AW'(a); reg_wdata_i = d; reg_we_i = w; cause_evt_i = e;
    #1;
    check(tag, reg_rdata_o, model_read(a));
    check("R10", {28'b0, sw_rst_no}, {28'b0, m_ctrl});
    @(posedge clk_i);
    if (rst_ni) begin
      if (w && a == 0) m_cause = m_cause & ~d[4:0];
      m_cause = m_cause | e;
      old_lock = m_lock;
      for (int i = 0; i < NCH; i++) begin
        if (w && a == 1 + 2*i && d[0]) m_lock[i] = 1'b0;
        if (w && a == 2 + 2*i && old_lock[i]) m_ctrl[i] = d[0];
      end
    end
    @(negedge clk_i);
  endtask

  // Read without advancing the clock
  task automatic peek(input int a, input logic [DW-1:0] exp, input string tag);
    reg_addr_i = AW'(a); reg_we_i = 1'b0; cause_evt_i = '0;
    #1;
    check(tag, reg_rdata_o, exp);
  endtask

  task automatic rd_all(input string tag);
    for (int a = 0; a <= 2*NCH + 2; a++) cyc(a, '0, 1'b0, '0, tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    model_reset();
    cyc(0, '0, 1'b0, 5'h1E, "R1");
    cyc(3, 32'h1, 1'b1, '0, "R1");
    rd_all("R1");
    rst_ni = 1'b1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; reg_addr_i = '0; reg_wdata_i = '0; reg_we_i = 1'b0; cause_evt_i = '0;
    model_reset();
    @(negedge clk_i);
    do_reset();
    rd_all("R1");
    peek(0, 32'h01, "R1");
    check("R1", {28'b0, sw_rst_no}, 32'hF);

    // R2: events accumulate
    cyc(0, '0, 1'b0, 5'h04, "R2");
    cyc(0, '0, 1'b0, 5'h18, "R2");
    peek(0, 32'h1D, "R2");

    // R3: write-0 keeps, write-1 clears
    cyc(0, 32'h0, 1'b1, '0, "R3");
    peek(0, 32'h1D, "R3");
    cyc(0, 32'h05, 1'b1, '0, "R3");
    peek(0, 32'h18, "R3");

    // R4: event beats clear
    cyc(0, 32'h18, 1'b1, 5'h08, "R4");
    peek(0, 32'h08, "R4");
    cyc(0, 32'hFFFF_FFFF, 1'b1, '0, "R3");
    peek(0, 32'h00, "R3");

    // R6 / R10: open channel 1 control
    cyc(4, 32'h0, 1'b1, '0, "R6");
    peek(4, 32'h0, "R6");
    check("R10", {28'b0, sw_rst_no}, 32'hD);
    cyc(4, 32'h1, 1'b1, '0, "R6");
    peek(4, 32'h1, "R6");

    // R5 / R7: channel 1 lock
    cyc(3, 32'h0, 1'b1, '0, "R5");
    peek(3, 32'h1, "R5");
    cyc(3, 32'h1, 1'b1, '0, "R5");
    peek(3, 32'h0, "R5");
    cyc(4, 32'h0, 1'b1, '0, "R7");
    peek(4, 32'h1, "R7");
    check("R7", {28'b0, sw_rst_no}, 32'hF);
    cyc(3, 32'h0, 1'b1, '0, "R5");
    peek(3, 32'h0, "R5");
    cyc(2, 32'h0, 1'b1, '0, "R6");
    peek(2, 32'h0, "R6");
    cyc(2, 32'h1, 1'b1, '0, "R6");

    // R7: channel 2 locked while held low
    cyc(6, 32'h0, 1'b1, '0, "R6");
    cyc(5, 32'h1, 1'b1, '0, "R5");
    cyc(6, 32'h1, 1'b1, '0, "R7");
    peek(6, 32'h0, "R7");
    check("R7", {28'b0, sw_rst_no}, 32'hB);

    // R8: upper write bits ignored, upper read bits zero
    cyc(8, 32'hFFFF_FFFE, 1'b1, '0, "R8");
    peek(8, 32'h0, "R8");
    cyc(8, 32'hFFFF_FFFF, 1'b1, '0, "R8");
    peek(8, 32'h1, "R8");
    peek(7, 32'h1, "R8");

    // R9: unmapped addresses
    cyc(9, 32'h0, 1'b1, '0, "R9");
    cyc(63, 32'hFFFF_FFFF, 1'b1, '0, "R9");
    cyc(10, 32'hFFFF_FFFF, 1'b1, '0, "R9");
    peek(9, 32'h0, "R9");
    peek(63, 32'h0, "R9");
    rd_all("R9");

    // Full reset reopens locks and releases outputs
    @(negedge clk_i);
    do_reset();
    peek(3, 32'h1, "R5");
    peek(6, 32'h1, "R1");
    check("R1", {28'b0, sw_rst_no}, 32'hF);

    // Mixed pass compared against the model every clock
    for (int i = 0; i < 400; i++) begin
      int a;
      logic [DW-1:0] d;
      a = (i * 7 + i / 13) % 12;
      d = DW'(i * 37) ^ DW'(i >> 2);
      cyc(a, d, (i % 3) != 0, (i % 5 == 0) ? 5'(i % 32) : 5'h0, "R8");
    end
    rd_all("R2");

    summary();
    $finish;
  end
endmodule